// File: doc/BRIEF.md
# Registered Read-Only Memory with Selectable Output Enable

This block is a 2048-word by 8-bit read-only store whose read path ends in an edge-triggered output register. A read address presented before a rising clock edge is looked up, and the word appears on the output after that edge. The output stays fixed until the next rising edge, so the address may move on to the next location while the current word is still being used.

A level-sensitive, active-low initialize input loads a separate stored word straight into the output register, with no clock needed. A stored configuration bit decides how the active-low output enable behaves. In one setting it acts on the output at once. In the other setting it passes through a register and takes effect only at the next rising edge. The three-state output is modelled as a data bus (`dataOut`, which always carries the register value) plus a drive flag (`dataOe`, 1 means the bus is driven).

The array, the initialize word and the configuration bit are loaded through a simple write port on a 12-bit programming address. A synchronous active-high reset models power-up.

Top module: `registeredRom`

## Requirements
- R1: With `wrEn` high at a rising edge, a programming address in 0x000–0x7FF stores `wrData` into the array word at that address.
- R2: At each rising edge, the array word at `addr` is captured into the output register and shown on `dataOut`. `dataOut` does not change between rising edges, whatever `addr` and `enN` do.
- R3: While `initN` is low, the output register holds the stored initialize word. It loads at once, with no clock, and neither clock edges nor `rst` override it.
- R4: The initialize word is written at programming address 0x800. A word of 0x00 makes initialize clear the register, and 0xFF makes it preset the register to all ones.
- R5: Bit 0 of a write to programming address 0x801 selects the enable mode: 0 means immediate (asynchronous) and 1 means clocked (synchronous).
- R6: In immediate mode, `dataOe` equals the inverse of `enN` at once, with no clock edge.
- R7: In clocked mode, `dataOe` changes only on a rising edge. After each edge it equals the inverse of the `enN` value sampled at that edge.
- R8: A rising edge with `rst` high clears the output register to 0x00 (unless `initN` is low). In clocked mode it also turns the enable state off, so `dataOe` is 0 after that edge. In immediate mode, `dataOe` still follows `enN`.
- R9: In immediate mode, after an initialize taken while `enN` is high, driving `enN` low shows the initialize word on a driven output.
- R10: Writes to programming addresses 0x802–0xFFF change nothing: the array, the initialize word and the mode stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-up reset |
| addr | input | 11 | Read address |
| enN | input | 1 | Active-low output enable |
| initN | input | 1 | Active-low, level-sensitive initialize |
| wrEn | input | 1 | Programming write strobe |
| wrAddr | input | 12 | Programming address |
| wrData | input | 8 | Programming data |
| dataOut | output | 8 | Output register contents |
| dataOe | output | 1 | Output drive flag (1 = driven) |

## Verification
Each result has its own due time:
- **Array reads and clocked-mode enables:** due one rising edge after their inputs. The bench drives inputs 5 ns after an edge and checks 5 ns after the following edge. It also checks just before that edge, to show nothing moved early.
- **Initialize and immediate-mode enables:** due with no edge at all. The bench checks them 1 ns after the input change, before any clock edge.
- **Initialize held low across an edge:** checked again after that edge, so the clocked capture is seen to lose.

// File: rtl/romPkg.sv
package romPkg;
  typedef struct packed {
    logic wrArray;
    logic wrInit;
    logic clrData;
  } romStrobes_t;
endpackage

// File: rtl/romCtrl.sv
module romCtrl
  import romPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enN,
  input  logic              wrEn,
  input  logic [ADDR_W:0]   wrAddr,
  input  logic              wrBit0,
  output romStrobes_t       strobes,
  output logic              syncMode,
  output logic              dataOe
);
  localparam int PROG_W = ADDR_W + 1;
  localparam logic [PROG_W-1:0] INIT_LOC = PROG_W'(1) << ADDR_W;
  localparam logic [PROG_W-1:0] CFG_LOC  = INIT_LOC + PROG_W'(1);

  logic cfgSync;
  logic enQ;

  // Programming decode: upper half of the map only holds two live locations
  always_comb begin
    strobes.wrArray = wrEn && !wrAddr[ADDR_W];
    strobes.wrInit  = wrEn && (wrAddr == INIT_LOC);
    strobes.clrData = rst;
  end

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr == CFG_LOC)) cfgSync <= wrBit0;
  end

  // Clocked enable state; reset puts it in the off condition
  always_ff @(posedge clk) begin
    if (rst) enQ <= 1'b1;
    else     enQ <= enN;
  end

  assign syncMode = cfgSync;
  assign dataOe   = cfgSync ? !enQ : !enN;
endmodule

// File: rtl/romDatapath.sv
module romDatapath
  import romPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              initN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  romStrobes_t       strobes,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] initWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strobes.wrArray) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobes.wrInit) initWord <= wrData;
  end

  assign rdWord = mem[addr];

  // Level-sensitive initialize wins over clock and reset
  always_ff @(posedge clk or negedge initN) begin
    if (!initN)               dataQ <= initWord;
    else if (strobes.clrData) dataQ <= '0;
    else                      dataQ <= rdWord;
  end
endmodule

// File: rtl/registeredRom.sv
module registeredRom
  import romPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enN,
  input  logic              initN,
  input  logic              wrEn,
  input  logic [ADDR_W:0]   wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  romStrobes_t       strobes;
  logic              syncMode;
  logic [DATA_W-1:0] initWordW;

  romCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .enN(enN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBit0(wrData[0]), .strobes(strobes), .syncMode(syncMode), .dataOe(dataOe)
  );

  romDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .initN(initN), .addr(addr), .wrIdx(wrAddr[ADDR_W-1:0]),
    .wrData(wrData), .strobes(strobes), .dataQ(dataOut), .initWord(initWordW)
  );
endmodule

// File: rtl/romChecker.sv
module romChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enN,
  input logic              initN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic [DATA_W-1:0] initWordSig,
  input logic              syncMode
);
  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !initN |-> dataOut == initWordSig);

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (syncMode && $past(syncMode) && !$past(rst)) |-> dataOe == !$past(enN));

  // R8
  sync_powerup_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && syncMode) |-> !dataOe);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && initN && $past(initN)) |-> dataOut == '0);
endmodule

bind registeredRom romChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .enN(enN), .initN(initN), .dataOut(dataOut),
  .dataOe(dataOe), .initWordSig(initWordW), .syncMode(syncMode)
);

// File: tb/tb_registeredRom.sv
`timescale 1ns/1ps
module tb_registeredRom;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] addr = '0;
  logic        enN = 1'b1;
  logic        initN = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  dataOut;
  logic        dataOe;

  logic [7:0] refMem [2048];
  logic [7:0] refInit;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  registeredRom dut (
    .clk(clk), .rst(rst), .addr(addr), .enN(enN), .initN(initN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic progWrite(input logic [11:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic readAt(input string req, input logic [10:0] a);
    addr = a;
    step();
    chk(req, dataOut, refMem[a]);
  endtask

  // R1, R4, R5: load array, init word, mode (immediate) under reset
  task automatic tProgram();
    for (int a = 0; a < 2048; a++) begin
      refMem[a] = 8'((a * 37) + (a >> 4) + 3);
      progWrite(12'(a), refMem[a]);
    end
    refInit = 8'h00;
    progWrite(12'h800, refInit);
    progWrite(12'h801, 8'h00);
  endtask

  // R8: reset state in immediate mode
  task automatic tReset();
    enN = 1'b1; rst = 1'b1;
    step(); step();
    chk("R8 reset clears register", dataOut, 8'h00);
    chk("R8 immediate mode oe off with enN high", {7'b0, dataOe}, 8'h00);
    rst = 1'b0;
  endtask

  // R1, R2: registered reads and stability between edges
  task automatic tReads();
    readAt("R1 R2 read 0x000", 11'h000);
    readAt("R1 R2 read 0x7FF", 11'h7FF);
    readAt("R2 read 0x555", 11'h555);
    readAt("R2 read 0x2AA", 11'h2AA);
    addr = 11'h123; #2;
    chk("R2 no change before edge", dataOut, refMem[11'h2AA]);
    enN = 1'b0; #2; enN = 1'b1;
    chk("R2 enable toggle leaves data", dataOut, refMem[11'h2AA]);
    step();
    chk("R2 read 0x123 after edge", dataOut, refMem[11'h123]);
  endtask

  // R6: immediate enable
  task automatic tAsyncEnable();
    enN = 1'b0; #1;
    chk("R6 oe on at once", {7'b0, dataOe}, 8'h01);
    enN = 1'b1; #1;
    chk("R6 oe off at once", {7'b0, dataOe}, 8'h00);
  endtask

  // R3, R4: initialize, clear/preset, held across an edge
  task automatic tInit();
    addr = 11'h005;
    step();
    initN = 1'b0; #1;
    chk("R4 init word 0x00 clears", dataOut, 8'h00);
    initN = 1'b1;
    step();
    chk("R2 read back after init", dataOut, refMem[5]);
    refInit = 8'hFF; progWrite(12'h800, refInit);
    initN = 1'b0; #1;
    chk("R4 init word 0xFF presets", dataOut, 8'hFF);
    initN = 1'b1;
    refInit = 8'hA5; progWrite(12'h800, refInit);
    initN = 1'b0; #1;
    chk("R3 init loads at once", dataOut, 8'hA5);
    step();
    chk("R3 init held across edge", dataOut, 8'hA5);
    initN = 1'b1; #1;
    chk("R3 release keeps word until edge", dataOut, 8'hA5);
    step();
    chk("R3 edge after release reads array", dataOut, refMem[5]);
  endtask

  // R9: init with outputs off, then enable
  task automatic tInitThenEnable();
    enN = 1'b1;
    initN = 1'b0; #1;
    chk("R9 oe off during init", {7'b0, dataOe}, 8'h00);
    enN = 1'b0; #1;
    chk("R9 oe on after enable", {7'b0, dataOe}, 8'h01);
    chk("R9 init word shown", dataOut, 8'hA5);
    initN = 1'b1; enN = 1'b1;
    step();
  endtask

  // R5, R7, R8: clocked mode
  task automatic tSyncMode();
    progWrite(12'h801, 8'h01);
    enN = 1'b0; rst = 1'b1;
    step();
    chk("R8 clocked mode oe off after reset", {7'b0, dataOe}, 8'h00);
    rst = 1'b0;
    step();
    chk("R5 R7 oe on one edge after enN low", {7'b0, dataOe}, 8'h01);
    enN = 1'b1; #1;
    chk("R7 oe holds before edge", {7'b0, dataOe}, 8'h01);
    step();
    chk("R7 oe off after edge", {7'b0, dataOe}, 8'h00);
    enN = 1'b0; #1;
    chk("R7 oe stays off before edge", {7'b0, dataOe}, 8'h00);
    step();
    chk("R7 oe back on after edge", {7'b0, dataOe}, 8'h01);
  endtask

  // R10: writes above 0x801 ignored
  task automatic tIgnored();
    progWrite(12'h802, 8'h00);
    progWrite(12'hFFF, 8'h11);
    progWrite(12'h9AB, 8'h22);
    progWrite(12'hC05, 8'h33);
    readAt("R10 array 0x7FF untouched", 11'h7FF);
    readAt("R10 array 0x1AB untouched", 11'h1AB);
    readAt("R10 array 0x405 untouched", 11'h405);
    readAt("R10 array 0x002 untouched", 11'h002);
    initN = 1'b0; #1;
    chk("R10 init word untouched", dataOut, refInit);
    initN = 1'b1;
    enN = 1'b1; #1;
    chk("R10 mode still clocked", {7'b0, dataOe}, 8'h01);
    step();
    chk("R10 mode still clocked after edge", {7'b0, dataOe}, 8'h00);
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #5;
    tProgram();
    tReset();
    tReads();
    tAsyncEnable();
    tInit();
    tInitThenEnable();
    tSyncMode();
    tIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule